// File: doc/BRIEF.md
# Status Ring Writer with Lap Stamping

The block takes completed status records from an upstream engine and stores them as 8-word entries (32 bits per word) in a circular ring of on-chip memory. The upstream side offers one record at a time over a valid/ready handshake. The record carries seven payload words. The block writes one word per clock at slot `head`, in word order, and adds an eighth word of its own. That last word holds a fixed 8-bit ring tag and a 4-bit lap stamp. When the eighth word is in memory, the head pointer moves to the next slot and a one-cycle interrupt pulse is raised.

The lap stamp lets a reader tell fresh entries from stale ones by looking only at the entries. Every entry written during the first trip around the ring carries stamp 1. The stamp steps by one each time the head wraps, and it rolls from 15 back to 0. A companion scanner acts as the consumer. On each scan request it reads the entry at its own read pointer and compares bit 0 of the stamp with the parity it expects next. If they match, it reports the entry as new and advances. The scanner's read pointer is the ring tail, and the tail is what stops the producer from overrunning unread entries.

Top module: `sring_writer`

## Requirements
- R1: After reset, `head` and `tail` are 0, `in_ready` is 1, `irq` is 0, and every ring word is zero. A scan of slot 0 therefore reports the slot as not new.
- R2: An accepted record is written as 8 consecutive single-cycle writes, starting in the cycle after acceptance. Word i of slot s goes to `mem_addr` = s*8+i, with i ascending from 0 to 7. Words 0 to 4 are the payload words unchanged. Payload word k is `in_payload[32k+31:32k]`.
- R3: Reserved bits are written as zero. These are bits [31:20] of word 5, all of word 6, and bits [19:0] of word 7. Bits [19:0] of word 5 come from the payload.
- R4: Word 7 carries the parameter `RING_TAG` in bits [27:20] and the lap stamp in bits [31:28]. Entries written on the first trip around the ring carry stamp 1.
- R5: The lap stamp increases by one for entries written after each head wrap. After 15 the next stamp is 0.
- R6: `head` advances by one in the cycle after word 7 is written, and wraps from `RING_SIZE-1` to 0. It changes at no other time.
- R7: `irq` is high for exactly one cycle, in the cycle after word 7 of an entry is written.
- R8: While an entry is being written, `in_ready` is 0. Changes to `in_valid` and `in_payload` in that period have no effect on the words written.
- R9: When `head+1` (modulo `RING_SIZE`) equals `tail`, `in_ready` is 0 and no write occurs while `in_valid` is held. The head therefore never moves onto the tail.
- R10: A scan request in one cycle gives `scan_valid` in the next, with `scan_slot`, `scan_word0` and `scan_word7` taken from the slot at `tail`. `scan_new` is 1 exactly when bit 28 of that word 7 equals the expected parity. The expected parity is 1 after reset and inverts each time the read pointer wraps.
- R11: `tail` advances by one, wrapping after `RING_SIZE-1`, only on a scan reported as new. A scan that is not new leaves `tail` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Record offered |
| in_ready | output | 1 | Record can be taken this cycle |
| in_payload | input | 224 | Seven payload words, word k at bits [32k+31:32k] |
| mem_we | output | 1 | Ring word write strobe |
| mem_addr | output | PTR_W+3 | Ring word address (slot*8 + word) |
| mem_wdata | output | 32 | Ring word write data |
| head | output | PTR_W | Next slot to be written |
| irq | output | 1 | One-cycle pulse after an entry completes |
| scan_req | input | 1 | Request to inspect the entry at the tail |
| scan_valid | output | 1 | Scan result available |
| scan_new | output | 1 | Scanned entry is fresh |
| scan_slot | output | PTR_W | Slot that was scanned |
| scan_word0 | output | 32 | Word 0 of the scanned entry |
| scan_word7 | output | 32 | Word 7 of the scanned entry |
| tail | output | PTR_W | Scanner read pointer |

## Verification
The bound assertions check the following on every cycle:
- writes go out in ascending word order, to the slot named by `head`;
- word 6 and the low part of word 7 are zero;
- `head` moves only in single steps with a wrap;
- `irq` is a single pulse that follows a word-7 write;
- `in_ready` is low during a write;
- `head` never lands on `tail`;
- every scan result answers a request.

Other behaviour needs the directed scenarios:
- the exact payload passed through and the masking of word 5;
- the tag and stamp values, and the stamp rolling from 15 to 0;
- holding off a full ring;
- the scanner telling stale slots from fresh ones across several parity flips.

// File: rtl/sring_pkg.sv
package sring_pkg;

    localparam int WORD_W      = 32;
    localparam int ENTRY_WORDS = 8;
    localparam int PAY_WORDS   = ENTRY_WORDS - 1;
    localparam int SLOT_SHIFT  = $clog2(ENTRY_WORDS);
    localparam int LAP_W       = 4;
    localparam int TAG_W       = 8;
    localparam int TAG_LSB     = 20;
    localparam int LAP_LSB     = TAG_LSB + TAG_W;
    localparam int MASKED_IDX  = 5;
    localparam int ZERO_IDX    = 6;
    localparam int KEEP5_W     = 20;

    typedef logic [WORD_W-1:0] word_t;

    // Layout of the closing word of every entry.
    typedef struct packed {
        logic [LAP_W-1:0]   lap;
        logic [TAG_W-1:0]   tag;
        logic [TAG_LSB-1:0] pad;
    } stamp_word_t;

    typedef enum logic {
        WR_IDLE,
        WR_BUSY
    } wr_state_e;

    // Clears the reserved parts of payload words.
    function automatic word_t scrub_word(input int unsigned idx, input word_t d);
        word_t r;
        r = d;
        if (idx == MASKED_IDX) begin
            r = word_t'(d[KEEP5_W-1:0]);
        end else if (idx == ZERO_IDX) begin
            r = '0;
        end
        return r;
    endfunction

    function automatic word_t make_stamp(input logic [TAG_W-1:0] tag,
                                         input logic [LAP_W-1:0] lap);
        stamp_word_t s;
        s.lap = lap;
        s.tag = tag;
        s.pad = '0;
        return word_t'(s);
    endfunction

endpackage

// File: rtl/sring_mem.sv
module sring_mem
    import sring_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output word_t             rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output word_t             rdata_b
);

    word_t store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                store_q[i] <= '0;
            end
        end else if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata_a = store_q[raddr_a];
    assign rdata_b = store_q[raddr_b];

endmodule

// File: rtl/sring_producer.sv
module sring_producer
    import sring_pkg::*;
#(
    parameter int               RING_SIZE = 8,
    parameter logic [TAG_W-1:0] RING_TAG  = 8'h5A,
    localparam int PTR_W  = $clog2(RING_SIZE),
    localparam int ADDR_W = PTR_W + SLOT_SHIFT
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [PAY_WORDS*WORD_W-1:0]  in_payload,
    input  logic [PTR_W-1:0]             tail,
    output logic                         wr_en,
    output logic [ADDR_W-1:0]            wr_addr,
    output word_t                        wr_data,
    output logic [PTR_W-1:0]             head,
    output logic                         irq
);

    localparam logic [PTR_W-1:0]      LAST_SLOT = PTR_W'(RING_SIZE - 1);
    localparam logic [SLOT_SHIFT-1:0] LAST_WORD = SLOT_SHIFT'(ENTRY_WORDS - 1);

    wr_state_e                        state_q;
    logic [SLOT_SHIFT-1:0]            word_q;
    logic [PAY_WORDS-1:0][WORD_W-1:0] pay_q;
    logic [PTR_W-1:0]                 head_q;
    logic [PTR_W-1:0]                 head_succ;
    logic [LAP_W-1:0]                 lap_q;
    logic                             irq_q;
    logic                             ring_full;
    logic                             accept;
    logic                             last_word;

    assign head_succ = (head_q == LAST_SLOT) ? '0 : head_q + 1'b1;
    assign ring_full = (head_succ == tail);
    assign in_ready  = (state_q == WR_IDLE) && !ring_full;
    assign accept    = in_valid && in_ready;
    assign last_word = (word_q == LAST_WORD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WR_IDLE;
            word_q  <= '0;
            pay_q   <= '0;
            head_q  <= '0;
            lap_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (state_q)
                WR_IDLE: begin
                    if (accept) begin
                        pay_q   <= in_payload;
                        word_q  <= '0;
                        state_q <= WR_BUSY;
                    end
                end
                WR_BUSY: begin
                    if (last_word) begin
                        state_q <= WR_IDLE;
                        head_q  <= head_succ;
                        irq_q   <= 1'b1;
                        if (head_q == LAST_SLOT) begin
                            lap_q <= lap_q + 1'b1;
                        end
                    end else begin
                        word_q <= word_q + 1'b1;
                    end
                end
                default: state_q <= WR_IDLE;
            endcase
        end
    end

    // Data for the word currently in flight.
    always_comb begin
        wr_data = '0;
        for (int i = 0; i < PAY_WORDS; i++) begin
            if (word_q == SLOT_SHIFT'(i)) begin
                wr_data = scrub_word(unsigned'(i), pay_q[i]);
            end
        end
        if (last_word) begin
            wr_data = make_stamp(RING_TAG, LAP_W'(lap_q + 1'b1));
        end
    end

    assign wr_en   = (state_q == WR_BUSY);
    assign wr_addr = {head_q, word_q};
    assign head    = head_q;
    assign irq     = irq_q;

endmodule

// File: rtl/sring_scanner.sv
module sring_scanner
    import sring_pkg::*;
#(
    parameter int RING_SIZE = 8,
    localparam int PTR_W = $clog2(RING_SIZE)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_req,
    input  word_t            first_word,
    input  word_t            stamp_word,
    output logic [PTR_W-1:0] rd_slot,
    output logic             scan_valid,
    output logic             scan_new,
    output logic [PTR_W-1:0] scan_slot,
    output word_t            scan_word0,
    output word_t            scan_word7
);

    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(RING_SIZE - 1);

    logic [PTR_W-1:0] rd_q;
    logic             parity_q;
    logic             fresh;
    logic             valid_q;
    logic             new_q;
    logic [PTR_W-1:0] slot_q;
    word_t            w0_q;
    word_t            w7_q;

    assign fresh = (stamp_word[LAP_LSB] == parity_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q     <= '0;
            parity_q <= 1'b1;
            valid_q  <= 1'b0;
            new_q    <= 1'b0;
            slot_q   <= '0;
            w0_q     <= '0;
            w7_q     <= '0;
        end else begin
            valid_q <= scan_req;
            if (scan_req) begin
                new_q  <= fresh;
                slot_q <= rd_q;
                w0_q   <= first_word;
                w7_q   <= stamp_word;
                if (fresh) begin
                    if (rd_q == LAST_SLOT) begin
                        rd_q     <= '0;
                        parity_q <= ~parity_q;
                    end else begin
                        rd_q <= rd_q + 1'b1;
                    end
                end
            end
        end
    end

    assign rd_slot    = rd_q;
    assign scan_valid = valid_q;
    assign scan_new   = new_q;
    assign scan_slot  = slot_q;
    assign scan_word0 = w0_q;
    assign scan_word7 = w7_q;

endmodule

// File: rtl/sring_writer.sv
module sring_writer
    import sring_pkg::*;
#(
    parameter int               RING_SIZE = 8,
    parameter logic [TAG_W-1:0] RING_TAG  = 8'h5A,
    localparam int PTR_W  = $clog2(RING_SIZE),
    localparam int ADDR_W = PTR_W + SLOT_SHIFT
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [PAY_WORDS*WORD_W-1:0] in_payload,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [WORD_W-1:0]           mem_wdata,
    output logic [PTR_W-1:0]            head,
    output logic                        irq,
    input  logic                        scan_req,
    output logic                        scan_valid,
    output logic                        scan_new,
    output logic [PTR_W-1:0]            scan_slot,
    output logic [WORD_W-1:0]           scan_word0,
    output logic [WORD_W-1:0]           scan_word7,
    output logic [PTR_W-1:0]            tail
);

    localparam int DEPTH = RING_SIZE * ENTRY_WORDS;
    localparam logic [SLOT_SHIFT-1:0] LAST_WORD = SLOT_SHIFT'(ENTRY_WORDS - 1);

    logic [PTR_W-1:0]  rd_slot;
    logic [ADDR_W-1:0] rd_addr_first;
    logic [ADDR_W-1:0] rd_addr_stamp;
    word_t             rd_first;
    word_t             rd_stamp;
    word_t             wr_data;

    assign rd_addr_first = {rd_slot, {SLOT_SHIFT{1'b0}}};
    assign rd_addr_stamp = {rd_slot, LAST_WORD};

    sring_producer #(
        .RING_SIZE (RING_SIZE),
        .RING_TAG  (RING_TAG)
    ) u_producer (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_payload (in_payload),
        .tail       (rd_slot),
        .wr_en      (mem_we),
        .wr_addr    (mem_addr),
        .wr_data    (wr_data),
        .head       (head),
        .irq        (irq)
    );

    sring_mem #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk     (clk),
        .rst     (rst),
        .we      (mem_we),
        .waddr   (mem_addr),
        .wdata   (wr_data),
        .raddr_a (rd_addr_first),
        .rdata_a (rd_first),
        .raddr_b (rd_addr_stamp),
        .rdata_b (rd_stamp)
    );

    sring_scanner #(
        .RING_SIZE (RING_SIZE)
    ) u_scanner (
        .clk        (clk),
        .rst        (rst),
        .scan_req   (scan_req),
        .first_word (rd_first),
        .stamp_word (rd_stamp),
        .rd_slot    (rd_slot),
        .scan_valid (scan_valid),
        .scan_new   (scan_new),
        .scan_slot  (scan_slot),
        .scan_word0 (scan_word0),
        .scan_word7 (scan_word7)
    );

    assign mem_wdata = wr_data;
    assign tail      = rd_slot;

endmodule

// File: rtl/sring_writer_chk.sv
module sring_writer_chk #(
    parameter int RING_SIZE = 8,
    parameter int PTR_W     = 3,
    parameter int ADDR_W    = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic [PTR_W-1:0]  head,
    input logic              irq,
    input logic              scan_req,
    input logic              scan_valid,
    input logic [PTR_W-1:0]  tail
);

    // R2: word index climbs by one inside an entry
    p_word_order_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_addr[2:0] != 3'd7) |=> (mem_we && mem_addr[2:0] == $past(mem_addr[2:0]) + 3'd1));

    // R2: every write targets the head slot
    p_write_at_head_r2: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[ADDR_W-1:3] == head));

    // R3: word 6 is all zero
    p_word6_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_addr[2:0] == 3'd6) |-> (mem_wdata == 32'd0));

    // R3: low part of word 7 is zero
    p_word7_pad_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_addr[2:0] == 3'd7) |-> (mem_wdata[19:0] == 20'd0));

    // R6: head moves one slot at a time, wrapping at the end
    p_head_step_r6: assert property (@(posedge clk) disable iff (rst)
        (head != $past(head)) |->
            (($past(head) == PTR_W'(RING_SIZE - 1)) ? (head == '0) : (head == $past(head) + 1'b1)));

    // R7: interrupt lasts one cycle
    p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R7: interrupt follows a word-7 write
    p_irq_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(mem_we && mem_addr[2:0] == 3'd7));

    // R8: no acceptance while writing
    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !in_ready);

    // R9: head never catches the tail
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (head != $past(head)) |-> (head != tail));

    // R10: each result answers a request
    p_scan_reply_r10: assert property (@(posedge clk) disable iff (rst)
        scan_valid |-> $past(scan_req));

endmodule

bind sring_writer sring_writer_chk #(
    .RING_SIZE (RING_SIZE),
    .PTR_W     (PTR_W),
    .ADDR_W    (ADDR_W)
) u_sring_writer_chk (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .head       (head),
    .irq        (irq),
    .scan_req   (scan_req),
    .scan_valid (scan_valid),
    .tail       (tail)
);

// File: tb/test_sring_writer.sv
`timescale 1ns/1ps
module test_sring_writer;

    localparam int         RING = 8;
    localparam logic [7:0] TAG  = 8'h3C;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [223:0] in_payload = '0;
    logic         mem_we;
    logic [5:0]   mem_addr;
    logic [31:0]  mem_wdata;
    logic [2:0]   head;
    logic         irq;
    logic         scan_req = 1'b0;
    logic         scan_valid;
    logic         scan_new;
    logic [2:0]   scan_slot;
    logic [31:0]  scan_word0;
    logic [31:0]  scan_word7;
    logic [2:0]   tail;

    int n_checks = 0;
    int n_fail   = 0;

    int          bhead  = 0;
    int          btail  = 0;
    int          bstamp = 1;
    bit          bexp   = 1'b1;
    int          nsent  = 0;
    int          zero_stamps = 0;
    logic [31:0] slot_w0    [RING];
    logic [3:0]  slot_stamp [RING];

    always #4 clk = ~clk;

    sring_writer #(.RING_SIZE(RING), .RING_TAG(TAG)) i_sring_writer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_payload(in_payload), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .head(head), .irq(irq), .scan_req(scan_req),
        .scan_valid(scan_valid), .scan_new(scan_new), .scan_slot(scan_slot),
        .scan_word0(scan_word0), .scan_word7(scan_word7), .tail(tail)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [223:0] mk_pay(input int n);
        logic [223:0] p;
        for (int i = 0; i < 7; i++) begin
            p[32*i +: 32] = {8'(n), 8'(i), 16'hC0DE ^ 16'(n * 7)};
        end
        if (n % 3 == 0) begin
            p[32*5 +: 32] = 32'hFFFF_FFFF;
            p[32*6 +: 32] = 32'hFFFF_FFFF;
        end
        return p;
    endfunction

    function automatic logic [31:0] exp_word(input logic [223:0] p, input int i, input logic [3:0] st);
        if (i < 5)  return p[32*i +: 32];
        if (i == 5) return p[32*5 +: 32] & 32'h000F_FFFF;
        if (i == 6) return 32'd0;
        return {st, TAG, 20'd0};
    endfunction

    // Send one record, hold valid with altered payload during the write, check every word.
    task automatic send_entry();
        logic [223:0] p;
        logic [3:0]   st;
        int           slot;
        p    = mk_pay(nsent);
        st   = 4'(bstamp);
        slot = bhead;
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 ready before send", 64'(in_ready), 64'd1);
        in_valid   = 1'b1;
        in_payload = p;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 0) in_payload = ~p;
            chk(mem_we == 1'b1, "R2 write strobe", 64'(mem_we), 64'd1);
            chk(mem_addr == 6'(slot * 8 + i), "R2 word address", 64'(mem_addr), 64'(slot * 8 + i));
            if (i == 7)
                chk(mem_wdata == exp_word(p, i, st), "R4 R5 stamp word", 64'(mem_wdata), 64'(exp_word(p, i, st)));
            else
                chk(mem_wdata == exp_word(p, i, st), "R2 R3 payload word", 64'(mem_wdata), 64'(exp_word(p, i, st)));
            chk(in_ready == 1'b0, "R8 ready low while writing", 64'(in_ready), 64'd0);
            chk(irq == 1'b0, "R7 no early irq", 64'(irq), 64'd0);
            if (i == 7) in_valid = 1'b0;
        end
        bhead = (slot == RING - 1) ? 0 : slot + 1;
        @(negedge clk);
        chk(irq == 1'b1, "R7 irq after last word", 64'(irq), 64'd1);
        chk(mem_we == 1'b0, "R8 no extra write", 64'(mem_we), 64'd0);
        chk(head == 3'(bhead), "R6 head advance", 64'(head), 64'(bhead));
        @(negedge clk);
        chk(irq == 1'b0, "R7 irq one cycle", 64'(irq), 64'd0);
        slot_w0[slot]    = p[31:0];
        slot_stamp[slot] = st;
        if (st == 4'd0) zero_stamps++;
        if (slot == RING - 1) bstamp = (bstamp + 1) % 16;
        nsent++;
    endtask

    task automatic do_scan(input bit want_new);
        int s;
        s = btail;
        @(negedge clk);
        scan_req = 1'b1;
        @(negedge clk);
        scan_req = 1'b0;
        chk(scan_valid == 1'b1, "R10 scan valid", 64'(scan_valid), 64'd1);
        chk(scan_new == want_new, "R10 new flag", 64'(scan_new), 64'(want_new));
        chk(scan_slot == 3'(s), "R10 scan slot", 64'(scan_slot), 64'(s));
        if (want_new) begin
            chk(scan_word0 == slot_w0[s], "R10 scan word0", 64'(scan_word0), 64'(slot_w0[s]));
            chk(scan_word7 == {slot_stamp[s], TAG, 20'd0}, "R4 scan word7", 64'(scan_word7),
                64'({slot_stamp[s], TAG, 20'd0}));
            btail = (s == RING - 1) ? 0 : s + 1;
            if (s == RING - 1) bexp = ~bexp;
        end
        chk(tail == 3'(btail), "R11 tail", 64'(tail), 64'(btail));
        @(negedge clk);
        chk(scan_valid == 1'b0, "R10 scan valid pulse", 64'(scan_valid), 64'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(head == 3'd0, "R1 head", 64'(head), 64'd0);
        chk(tail == 3'd0, "R1 tail", 64'(tail), 64'd0);
        chk(in_ready == 1'b1, "R1 ready", 64'(in_ready), 64'd1);
        chk(irq == 1'b0, "R1 irq", 64'(irq), 64'd0);
        do_scan(1'b0);
    endtask

    task automatic t_fill_full();
        for (int k = 0; k < RING - 1; k++) send_entry();
        @(negedge clk);
        chk(in_ready == 1'b0, "R9 full ring not ready", 64'(in_ready), 64'd0);
        in_valid   = 1'b1;
        in_payload = mk_pay(999);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(mem_we == 1'b0, "R9 no write when full", 64'(mem_we), 64'd0);
            chk(head == 3'(RING - 1), "R9 head held", 64'(head), 64'(RING - 1));
        end
        in_valid = 1'b0;
    endtask

    task automatic t_drain();
        for (int k = 0; k < RING - 1; k++) do_scan(1'b1);
        do_scan(1'b0);
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 ready after drain", 64'(in_ready), 64'd1);
    endtask

    task automatic t_laps();
        for (int k = 0; k < 130; k++) begin
            do_scan(1'b0);
            send_entry();
            do_scan(1'b1);
        end
        chk(zero_stamps > 0, "R5 stamp rolled to 0", 64'(zero_stamps), 64'd1);
    endtask

    initial begin
        for (int i = 0; i < RING; i++) begin
            slot_w0[i]    = '0;
            slot_stamp[i] = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill_full();
        t_drain();
        t_laps();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule